// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the low-order address bits that step a memory access through a burst of beats. When a new access begins, a load strobe captures a start value taken from the low bits of the external address. That value is the first beat address. Each later clock edge with the active-low advance input asserted moves to the next beat. An edge with advance deasserted is a wait cycle, and the current beat is presented again.

The beat order depends on a mode input that is expected to stay static. With mode high, the order is interleaved: each address is the start value XOR the beat index. With mode low, the order is linear: each address is the start value plus the beat index, wrapping modulo the burst length. The upper address bits bypass this block. Because the index wraps inside the burst, no advance ever carries into them. The default width is two bits, which gives four beats.

Control is a two-state machine. `ST_IDLE` is entered at reset and means that no burst has been loaded yet. In `ST_IDLE` advance is ignored. `ST_BURST` is entered from either state on any edge with load high. It stays there and counts or holds the beat index. The transitions are reset→`ST_IDLE`, `ST_IDLE`→`ST_BURST` on load, `ST_BURST`→`ST_BURST` on load (restart), advance (step) or wait (hold), and `ST_IDLE`→`ST_IDLE` without load.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `beat_idx` is 0 and `beat_addr` is 0.
- R2: After an edge with `load` high, `beat_idx` is 0 and `beat_addr` equals the `start_bits` value sampled at that edge, in either mode.
- R3: With `mode` low (linear), `beat_addr` equals (start + `beat_idx`) modulo 4, e.g. start 01 gives 01, 10, 11, 00.
- R4: With `mode` high (interleaved), `beat_addr` equals start XOR `beat_idx`, e.g. start 01 gives 01, 00, 11, 10.
- R5: After an edge in the burst state with `load` low and `adv_n` low, `beat_idx` has increased by one modulo 4.
- R6: After an edge with `load` low and `adv_n` high, `beat_idx` and the start value are unchanged, so the beat repeats.
- R7: When `load` is high and `adv_n` is low on the same edge, the load wins: `beat_idx` becomes 0 and the new start is taken.
- R8: After four advances from a load, `beat_addr` is back at the start value. Further advances keep cycling through the same four addresses.
- R9: Before the first load after reset, `adv_n` low has no effect: `beat_idx` and `beat_addr` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Begin a new burst from `start_bits` |
| start_bits | input | AW (2) | Low bits of the external address |
| adv_n | input | 1 | Active-low advance; high means wait cycle |
| mode | input | 1 | 1 = interleaved order, 0 = linear order |
| beat_addr | output | AW (2) | Current beat's low address bits |
| beat_idx | output | AW (2) | Position of the current beat in the burst |

## Verification
The assertions guard only the beat index and the first-beat address. They take for granted that `mode` is static while a burst runs, because the address output follows `mode` combinationally. They also take for granted that `load`, `adv_n` and `start_bits` are known at each rising edge. The stimulus drives all inputs on the falling edge and changes `mode` only at segment boundaries. Each segment opens with a load and runs with `mode` fixed. Random load, advance and start values sit between directed runs for reset, pre-load advance, wrap and load-versus-advance collisions.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bseq_state_e;

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
#(
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv_n,
    input  logic [AW-1:0] start_bits,
    output logic [AW-1:0] start_q,
    output logic [AW-1:0] idx_q
);

    bseq_state_e   state_q, state_d;
    logic [AW-1:0] start_d, idx_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start_q <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            start_q <= start_d;
            idx_q   <= idx_d;
        end
    end

    // next state and next counters
    always_comb begin
        state_d = state_q;
        start_d = start_q;
        idx_d   = idx_q;
        if (load) begin
            state_d = ST_BURST;
            start_d = start_bits;
            idx_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    idx_d = '0;
                end
                ST_BURST: begin
                    if (!adv_n) idx_d = idx_q + AW'(1);
                end
                default: ;
            endcase
        end
    end

    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !load && !adv_n) |=> (idx_q == AW'($past(idx_q) + 1'b1)));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n) |=> ($stable(idx_q) && $stable(start_q)));

    a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !adv_n) |=> (idx_q == '0));

    a_r9_idle_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load) |=> (idx_q == '0));

endmodule

// File: rtl/bseq_order.sv
module bseq_order #(
    parameter int AW = 2
) (
    input  logic          mode,
    input  logic [AW-1:0] start_q,
    input  logic [AW-1:0] idx_q,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] ilv, lin;

    // interleaved order: bitwise XOR of start and beat index
    for (genvar b = 0; b < AW; b++) begin : g_ilv
        assign ilv[b] = start_q[b] ^ idx_q[b];
    end

    // linear order: modular add, carry drops out of the field
    assign lin  = start_q + idx_q;
    assign addr = mode ? ilv : lin;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] start_bits,
    input  logic          adv_n,
    input  logic          mode,
    output logic [AW-1:0] beat_addr,
    output logic [AW-1:0] beat_idx
);

    logic [AW-1:0] start_q, idx_q;

    bseq_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .adv_n      (adv_n),
        .start_bits (start_bits),
        .start_q    (start_q),
        .idx_q      (idx_q)
    );

    bseq_order #(.AW(AW)) u_order (
        .mode    (mode),
        .start_q (start_q),
        .idx_q   (idx_q),
        .addr    (beat_addr)
    );

    assign beat_idx = idx_q;

    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_addr == $past(start_bits) && beat_idx == '0));

endmodule

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;

    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [AW-1:0] start_bits = '0;
    logic          adv_n = 1'b1;
    logic          mode = 1'b1;
    logic [AW-1:0] beat_addr, beat_idx;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    // bench model
    bit            m_started = 0;
    logic [AW-1:0] m_start = '0;
    logic [AW-1:0] m_idx = '0;

    always #4 clk = ~clk;

    burst_addr_seq #(.AW(AW)) u_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .load(load), .start_bits(start_bits),
        .adv_n(adv_n), .mode(mode), .beat_addr(beat_addr), .beat_idx(beat_idx)
    );

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] s, logic [AW-1:0] i, logic m);
        logic [AW-1:0] r;
        if (m) r = s ^ i;
        else   r = AW'(s + i);
        return r;
    endfunction

    task automatic check(string tag);
        logic [AW-1:0] ea;
        ea = exp_addr(m_start, m_idx, mode);
        checks++;
        if (beat_addr !== ea || beat_idx !== m_idx) begin
            errors++;
            $display("FAIL %s: addr=%0d idx=%0d expected addr=%0d idx=%0d",
                     tag, beat_addr, beat_idx, ea, m_idx);
        end
    endtask

    // drive inputs (already at a falling edge), clock once, update model, check
    task automatic step(bit ld, logic [AW-1:0] sb, bit an, string tag);
        load = ld; start_bits = sb; adv_n = an;
        @(posedge clk);
        if (ld) begin
            m_started = 1; m_start = sb; m_idx = '0;
        end else if (m_started && !an) begin
            m_idx = AW'(m_idx + 1'b1);
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        string tag;
        bit ld, an;
        logic [AW-1:0] sb;
        seed = 32'h1F2E3D;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R9: advance before any load
        for (int k = 0; k < 3; k++) step(0, 2'd3, 0, "R9");

        // R4 + R8: interleaved from 01, six advances
        mode = 1'b1;
        step(1, 2'd1, 1, "R2");
        for (int k = 0; k < 4; k++) step(0, 2'd0, 0, "R4");
        if (beat_addr != 2'd1) begin errors++; $display("FAIL R8: addr=%0d expected 1", beat_addr); end
        checks++;
        step(0, 2'd0, 0, "R8");
        step(0, 2'd0, 0, "R8");

        // R3 + R8: linear from 01 (01,10,11,00,01)
        mode = 1'b0;
        step(1, 2'd1, 1, "R2");
        for (int k = 0; k < 3; k++) step(0, 2'd0, 0, "R3");
        if (beat_addr != 2'd0) begin errors++; $display("FAIL R3: addr=%0d expected 0", beat_addr); end
        checks++;
        step(0, 2'd0, 0, "R8");
        if (beat_addr != 2'd1) begin errors++; $display("FAIL R8: addr=%0d expected 1", beat_addr); end
        checks++;

        // R6 wait cycles, R5 step, R7 collision
        step(0, 2'd2, 1, "R6");
        step(0, 2'd2, 1, "R6");
        step(0, 2'd0, 0, "R5");
        step(1, 2'd2, 0, "R7");
        step(1, 2'd3, 0, "R7");

        // constrained random segments with fixed mode
        for (int seg = 0; seg < 40; seg++) begin
            mode = 1'($urandom_range(0, 1));
            step(1, AW'($urandom), 1'($urandom), "R2");
            for (int c = 0; c < 50; c++) begin
                ld = ($urandom_range(0, 9) == 0);
                an = ($urandom_range(0, 3) == 0);
                sb = AW'($urandom);
                if (ld && !an) tag = "R7";
                else if (ld)   tag = "R2";
                else if (an)   tag = "R6";
                else if (mode) tag = "R4";
                else           tag = "R3";
                step(ld, sb, an, tag);
            end
        end

        // reset again mid-burst, then R9 once more
        rst_n = 1'b0;
        m_started = 0; m_start = '0; m_idx = '0;
        @(negedge clk);
        @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        step(0, 2'd2, 0, "R9");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule